// File: doc/BRIEF.md
# Dual-Pipe Instruction Byte Queue

This block decouples an instruction fetch unit from two decode pipes. Each cycle fetch may offer up to two 32-byte blocks, each aligned on a 32-byte boundary. Every block is steered to one decode pipe and split into 16-byte window entries. Each pipe owns a private ring of entries. Each entry carries the window bytes, the thread identifier, the block's sequence tag, a half bit (0 for the lower window, 1 for the upper) and the byte offset where decoding starts within the window. Because blocks from different basic blocks can land in the two pipes out of program order, the sequence tag plus half bit lets later logic restore order.

Each pipe presents its two oldest entries to its decoder, which returns a consume count every cycle. In single-thread mode fetch chooses the pipe for each block. In two-thread mode a block always goes to the pipe numbered by its thread. A per-thread flush empties the affected queues in one cycle. A pipe only takes a block when two entries are free, so a block is never split across a full condition.

Top module: `ibq_dual`

## Requirements
- R1: After reset both queues are empty, both `pipe_ready` bits are 1 and every `hd_valid` bit is 0.
- R2: An accepted block whose start offset is below 16 adds two entries to its pipe. The first entry holds bytes 0..15 (data bits 127:0), has half=0 and ofs=start. The second holds bytes 16..31, has half=1 and ofs=0. Both entries carry the block's tid and seq.
- R3: An accepted block whose start offset is 16 or more adds one entry, holding bytes 16..31, with half=1 and ofs=start-16.
- R4: In single-thread mode (`smt_mode`=0) a block goes to pipe `fb_pipe_sel`. In two-thread mode a block goes to pipe `fb_tid`, and `fb_pipe_sel` has no effect.
- R5: Two valid blocks aimed at different pipes are both accepted in the same cycle. If both aim at the same pipe, only block 0 may be accepted, and block 1 is refused.
- R6: `pipe_ready[p]` is 1 exactly when pipe p holds at most DEPTH-2 entries. A block aimed at a pipe that is not ready is refused, and that queue gains nothing.
- R7: Slot 0 of a pipe shows its oldest entry and slot 1 the next oldest. `hd_valid[p][s]` is 1 when the pipe holds more than s entries.
- R8: `dec_consume[p]` removes 0, 1 or 2 entries from the head. A value of 3 acts as 2. The removal is limited to the number of entries held.
- R9: In two-thread mode `flush_tid[t]` empties pipe t only. In single-thread mode any flush bit empties both pipes. A flushed pipe refuses blocks in the flush cycle, and consumes in that cycle have no further effect.
- R10: Each pipe holds up to DEPTH (default 20) entries and returns them in arrival order across pointer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smt_mode | input | 1 | 1 = two-thread mode, 0 = single-thread mode |
| fb_valid | input | 2 | Block offered, per fetch slot |
| fb_pipe_sel | input | 2 | Target pipe per slot (single-thread mode) |
| fb_tid | input | 2 | Thread of each offered block |
| fb_data | input | 2x256 | Block bytes, byte 0 in bits 7:0 |
| fb_seq | input | 2x8 | Sequence tag per block |
| fb_start | input | 2x5 | Start byte offset within the block |
| fb_accept | output | 2 | Block taken this cycle, per slot |
| dec_consume | input | 2x2 | Entries consumed per pipe |
| flush_tid | input | 2 | Flush request per thread |
| pipe_ready | output | 2 | Pipe has room for a full block |
| hd_valid | output | 2x2 | Head slot valid [pipe][slot] |
| hd_data | output | 2x2x128 | Head window bytes |
| hd_tid | output | 2x2 | Head entry thread |
| hd_seq | output | 2x2x8 | Head entry sequence tag |
| hd_half | output | 2x2 | Head entry window half |
| hd_ofs | output | 2x2x4 | Head entry start offset |

## Verification
`fb_accept` is a same-cycle answer, so the bench samples it 5 ns after driving the inputs and before the rising edge. Writes, consumes and flushes show up on `hd_*` and `pipe_ready` one edge later, and the bench samples those at the following falling edge. A bench model holding one queue per pipe advances once per rising edge. The bench compares it against every head slot and ready bit each cycle, so any result that arrives early or late is caught in the cycle it is due.

// File: rtl/ibq_pkg.sv
package ibq_pkg;
  localparam int WIN_BYTES = 16;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int BLK_W     = 2 * WIN_W;
  localparam int OFS_W     = $clog2(WIN_BYTES);
  localparam int BOFS_W    = OFS_W + 1;
  localparam int SEQ_W     = 8;

  typedef struct packed {
    logic [WIN_W-1:0] data;
    logic             tid;
    logic [SEQ_W-1:0] seq;
    logic             half;
    logic [OFS_W-1:0] ofs;
  } ibq_entry_t;
endpackage

// File: rtl/ibq_split.sv
module ibq_split
  import ibq_pkg::*;
(
  input  logic [BLK_W-1:0]  blk_data,
  input  logic              blk_tid,
  input  logic [SEQ_W-1:0]  blk_seq,
  input  logic [BOFS_W-1:0] blk_start,
  output ibq_entry_t        first,
  output ibq_entry_t        second,
  output logic              two
);
  logic in_upper;
  assign in_upper = blk_start[BOFS_W-1];

  always_comb begin
    second.data = blk_data[BLK_W-1:WIN_W];
    second.tid  = blk_tid;
    second.seq  = blk_seq;
    second.half = 1'b1;
    second.ofs  = '0;
    first.tid   = blk_tid;
    first.seq   = blk_seq;
    if (in_upper) begin
      first.data = blk_data[BLK_W-1:WIN_W];
      first.half = 1'b1;
      first.ofs  = blk_start[OFS_W-1:0];
      two        = 1'b0;
    end else begin
      first.data = blk_data[WIN_W-1:0];
      first.half = 1'b0;
      first.ofs  = blk_start[OFS_W-1:0];
      two        = 1'b1;
    end
  end
endmodule

// File: rtl/ibq_steer.sv
module ibq_steer (
  input  logic       smt_mode,
  input  logic [1:0] valid,
  input  logic [1:0] pipe_sel,
  input  logic [1:0] tid,
  input  logic [1:0] ready,
  input  logic [1:0] pflush,
  output logic [1:0] tgt,
  output logic [1:0] acc
);
  logic clash;
  always_comb begin
    tgt    = smt_mode ? tid : pipe_sel;
    clash  = valid[0] && (tgt[0] == tgt[1]);
    acc[0] = valid[0] && ready[tgt[0]] && !pflush[tgt[0]];
    acc[1] = valid[1] && ready[tgt[1]] && !pflush[tgt[1]] && !clash;
  end
endmodule

// File: rtl/ibq_pipe_fifo.sv
module ibq_pipe_fifo
  import ibq_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic [1:0] wr_n,
  input  ibq_entry_t wr_a,
  input  ibq_entry_t wr_b,
  input  logic [1:0] consume,
  output logic       ready,
  output ibq_entry_t hd0,
  output ibq_entry_t hd1,
  output logic [1:0] hd_valid
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - 2);

  ibq_entry_t mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0] take;

  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] p,
                                                input logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    take = (consume == 2'd3) ? 2'd2 : consume;
    if (CNT_W'(take) > cnt_q) take = cnt_q[1:0];
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (wr_n != 2'd0) mem[wr_q] <= wr_a;
      if (wr_n == 2'd2) mem[ring_add(wr_q, 2'd1)] <= wr_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= ring_add(rd_q, take);
      wr_q  <= ring_add(wr_q, wr_n);
      cnt_q <= cnt_q - CNT_W'(take) + CNT_W'(wr_n);
    end
  end

  assign ready    = (cnt_q <= ROOM_MAX);
  assign hd0      = mem[rd_q];
  assign hd1      = mem[ring_add(rd_q, 2'd1)];
  assign hd_valid = {cnt_q >= CNT_W'(2), cnt_q != '0};

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  assert_write_needs_room_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_n != 2'd0) |-> (cnt_q <= ROOM_MAX));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0));
  assert_consume_no_growth_R8: assert property (@(posedge clk) disable iff (rst)
    (!flush && wr_n == 2'd0) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/ibq_dual.sv
module ibq_dual
  import ibq_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              smt_mode,
  input  logic [1:0]                        fb_valid,
  input  logic [1:0]                        fb_pipe_sel,
  input  logic [1:0]                        fb_tid,
  input  logic [1:0][BLK_W-1:0]             fb_data,
  input  logic [1:0][SEQ_W-1:0]             fb_seq,
  input  logic [1:0][BOFS_W-1:0]            fb_start,
  output logic [1:0]                        fb_accept,
  input  logic [1:0][1:0]                   dec_consume,
  input  logic [1:0]                        flush_tid,
  output logic [1:0]                        pipe_ready,
  output logic [1:0][1:0]                   hd_valid,
  output logic [1:0][1:0][WIN_W-1:0]        hd_data,
  output logic [1:0][1:0]                   hd_tid,
  output logic [1:0][1:0][SEQ_W-1:0]        hd_seq,
  output logic [1:0][1:0]                   hd_half,
  output logic [1:0][1:0][OFS_W-1:0]        hd_ofs
);
  logic [1:0] tgt, acc, pflush, rdy;
  ibq_entry_t [1:0] sp_a, sp_b;
  logic [1:0] sp_two;

  assign pflush = smt_mode ? flush_tid : {2{|flush_tid}};

  for (genvar i = 0; i < 2; i++) begin : g_split
    ibq_split u_split (
      .blk_data (fb_data[i]),
      .blk_tid  (fb_tid[i]),
      .blk_seq  (fb_seq[i]),
      .blk_start(fb_start[i]),
      .first    (sp_a[i]),
      .second   (sp_b[i]),
      .two      (sp_two[i])
    );
  end

  ibq_steer u_steer (
    .smt_mode(smt_mode),
    .valid   (fb_valid),
    .pipe_sel(fb_pipe_sel),
    .tid     (fb_tid),
    .ready   (rdy),
    .pflush  (pflush),
    .tgt     (tgt),
    .acc     (acc)
  );

  assign fb_accept  = acc;
  assign pipe_ready = rdy;

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    logic [1:0] wr_n;
    ibq_entry_t wr_a, wr_b, h0, h1;
    logic [1:0] hv;
    logic       rdy_p;

    always_comb begin
      wr_n = 2'd0;
      wr_a = sp_a[0];
      wr_b = sp_b[0];
      if (acc[0] && tgt[0] == 1'(p)) begin
        wr_n = sp_two[0] ? 2'd2 : 2'd1;
      end else if (acc[1] && tgt[1] == 1'(p)) begin
        wr_n = sp_two[1] ? 2'd2 : 2'd1;
        wr_a = sp_a[1];
        wr_b = sp_b[1];
      end
    end

    ibq_pipe_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .flush   (pflush[p]),
      .wr_n    (wr_n),
      .wr_a    (wr_a),
      .wr_b    (wr_b),
      .consume (dec_consume[p]),
      .ready   (rdy_p),
      .hd0     (h0),
      .hd1     (h1),
      .hd_valid(hv)
    );

    assign rdy[p]        = rdy_p;
    assign hd_valid[p]   = hv;
    assign hd_data[p][0] = h0.data;
    assign hd_data[p][1] = h1.data;
    assign hd_tid[p]     = {h1.tid, h0.tid};
    assign hd_seq[p][0]  = h0.seq;
    assign hd_seq[p][1]  = h1.seq;
    assign hd_half[p]    = {h1.half, h0.half};
    assign hd_ofs[p][0]  = h0.ofs;
    assign hd_ofs[p][1]  = h1.ofs;
  end

  assert_one_block_per_pipe_R5: assert property (@(posedge clk) disable iff (rst)
    (fb_accept == 2'b11) |-> (tgt[0] != tgt[1]));
  assert_st_flush_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (!smt_mode && flush_tid != 2'b00) |-> (fb_accept == 2'b00));
endmodule

// File: tb/ibq_dual_bench.sv
`timescale 1ns/1ps
module ibq_dual_bench;
  import ibq_pkg::*;
  localparam int DEPTH = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smt_mode = 1'b0;
  logic [1:0] fb_valid = '0, fb_pipe_sel = '0, fb_tid = '0, fb_accept;
  logic [1:0][BLK_W-1:0] fb_data = '0;
  logic [1:0][SEQ_W-1:0] fb_seq = '0;
  logic [1:0][BOFS_W-1:0] fb_start = '0;
  logic [1:0][1:0] dec_consume = '0;
  logic [1:0] flush_tid = '0, pipe_ready;
  logic [1:0][1:0] hd_valid, hd_tid, hd_half;
  logic [1:0][1:0][WIN_W-1:0] hd_data;
  logic [1:0][1:0][SEQ_W-1:0] hd_seq;
  logic [1:0][1:0][OFS_W-1:0] hd_ofs;

  int nchk = 0, nerr = 0;
  ibq_entry_t mq0[$], mq1[$];

  always #10 clk = ~clk;

  ibq_dual #(.DEPTH(DEPTH)) u_ibq_dual (.*);

  task automatic chk(input string r, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  function automatic int msize(input int p);
    return (p == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic ibq_entry_t mk(input int i, input logic up, input logic [OFS_W-1:0] o);
    ibq_entry_t e;
    e.data = up ? fb_data[i][BLK_W-1:WIN_W] : fb_data[i][WIN_W-1:0];
    e.tid  = fb_tid[i];
    e.seq  = fb_seq[i];
    e.half = up;
    e.ofs  = o;
    return e;
  endfunction

  task automatic mpush(input int p, input ibq_entry_t e);
    if (p == 0) mq0.push_back(e); else mq1.push_back(e);
  endtask

  // one cycle: inputs already driven at a falling edge
  task automatic step(input string r);
    logic [1:0] tg, pf, ex_acc, ex_rdy;
    for (int p = 0; p < 2; p++) ex_rdy[p] = (msize(p) <= DEPTH - 2);
    tg = smt_mode ? fb_tid : fb_pipe_sel;
    pf = smt_mode ? flush_tid : {2{|flush_tid}};
    ex_acc[0] = fb_valid[0] && ex_rdy[tg[0]] && !pf[tg[0]];
    ex_acc[1] = fb_valid[1] && ex_rdy[tg[1]] && !pf[tg[1]] &&
                !(fb_valid[0] && tg[0] == tg[1]);
    #5;
    chk(r, "accept", 160'(fb_accept), 160'(ex_acc));
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      if (pf[p]) begin
        if (p == 0) mq0.delete(); else mq1.delete();
      end else begin
        int n = (dec_consume[p] == 2'd3) ? 2 : int'(dec_consume[p]);
        if (n > msize(p)) n = msize(p);
        repeat (n) begin
          if (p == 0) void'(mq0.pop_front()); else void'(mq1.pop_front());
        end
        for (int i = 0; i < 2; i++) begin
          if (ex_acc[i] && tg[i] == 1'(p)) begin
            if (fb_start[i] < 5'd16) begin
              mpush(p, mk(i, 1'b0, fb_start[i][OFS_W-1:0]));
              mpush(p, mk(i, 1'b1, '0));
            end else begin
              mpush(p, mk(i, 1'b1, fb_start[i][OFS_W-1:0]));
            end
          end
        end
      end
    end
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(r, $sformatf("ready p%0d", p), 160'(pipe_ready[p]),
          160'(msize(p) <= DEPTH - 2));
      for (int s = 0; s < 2; s++) begin
        chk(r, $sformatf("valid p%0d s%0d", p, s), 160'(hd_valid[p][s]),
            160'(msize(p) > s));
        if (msize(p) > s) begin
          ibq_entry_t a, e;
          a.data = hd_data[p][s]; a.tid = hd_tid[p][s]; a.seq = hd_seq[p][s];
          a.half = hd_half[p][s]; a.ofs = hd_ofs[p][s];
          e = (p == 0) ? mq0[s] : mq1[s];
          chk(r, $sformatf("entry p%0d s%0d", p, s), 160'(a), 160'(e));
        end
      end
    end
  endtask

  task automatic idle();
    fb_valid = '0; dec_consume = '0; flush_tid = '0;
  endtask

  task automatic offer(input int i, input logic sel, input logic tid,
                       input logic [SEQ_W-1:0] seq, input logic [BOFS_W-1:0] st);
    fb_valid[i] = 1'b1; fb_pipe_sel[i] = sel; fb_tid[i] = tid;
    fb_seq[i] = seq; fb_start[i] = st;
    for (int k = 0; k < 8; k++) fb_data[i][k*32 +: 32] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1b9));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    step("R1");
    // R2 block at offset 5 into pipe 0
    offer(0, 1'b0, 1'b0, 8'd5, 5'd5); step("R2"); idle();
    // R3 block entered in its upper window, pipe 1
    offer(0, 1'b1, 1'b1, 8'd6, 5'd21); step("R3"); idle();
    flush_tid = 2'b01; step("R9"); idle();
    // R4 two-thread mode: tid decides, pipe select ignored
    smt_mode = 1'b1;
    offer(0, 1'b0, 1'b1, 8'd7, 5'd0); step("R4"); idle();
    offer(1, 1'b1, 1'b0, 8'd8, 5'd16); step("R4"); idle();
    // R5 both to same pipe, then to different pipes
    offer(0, 1'b0, 1'b1, 8'd9, 5'd2); offer(1, 1'b0, 1'b1, 8'd10, 5'd3); step("R5"); idle();
    offer(0, 1'b0, 1'b0, 8'd11, 5'd2); offer(1, 1'b0, 1'b1, 8'd12, 5'd3); step("R5"); idle();
    // R9 two-thread flush of thread 0 leaves pipe 1 intact
    flush_tid = 2'b01; offer(0, 1'b0, 1'b0, 8'd13, 5'd0); step("R9"); idle();
    flush_tid = 2'b10; step("R9"); idle();
    // R6 fill pipe 0 in single-thread mode until refused
    smt_mode = 1'b0;
    for (int k = 0; k < 12; k++) begin
      offer(0, 1'b0, 1'b0, 8'(20 + k), 5'd0); step("R6"); idle();
    end
    // R8 consume 3 acts as 2, then drain with clamp
    dec_consume[0] = 2'd3; step("R8"); idle();
    offer(0, 1'b0, 1'b0, 8'd40, 5'd0); step("R6"); idle();
    for (int k = 0; k < 12; k++) begin dec_consume[0] = 2'd2; step("R8"); end
    idle();
    offer(0, 1'b1, 1'b0, 8'd41, 5'd30); step("R3"); idle();
    dec_consume[1] = 2'd2; step("R8"); idle();
    // R9 single-thread flush clears both pipes
    offer(0, 1'b0, 1'b0, 8'd42, 5'd0); offer(1, 1'b1, 1'b1, 8'd43, 5'd0); step("R5"); idle();
    flush_tid = 2'b10; offer(0, 1'b0, 1'b0, 8'd44, 5'd0); step("R9"); idle();
    // R10 random traffic with wrap, both modes
    for (int seg = 0; seg < 6; seg++) begin
      flush_tid = 2'b11; step("R9"); idle();
      smt_mode = seg[0];
      for (int c = 0; c < 500; c++) begin
        for (int i = 0; i < 2; i++)
          if ($urandom_range(2) != 0)
            offer(i, 1'($urandom), 1'($urandom), 8'($urandom), 5'($urandom));
        dec_consume[0] = 2'($urandom);
        dec_consume[1] = 2'($urandom);
        if ($urandom_range(40) == 0) flush_tid = 2'($urandom);
        step("R10");
        idle();
      end
    end
    step("R7");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule